// File: doc/BRIEF.md
# Register Window Pointer Controller

This block controls the current window pointer of an eight-window register file, together with the window invalid mask and three mode bits: trap enable, supervisor, and previous supervisor. It accepts one request per cycle from the execute stage. The requests are a window push, a window pop, a return from trap, a trap entry, and a privileged read or write of the invalid mask. For each request it decides whether a trap is raised. If there is no trap, it updates its state and tells the register file which physical entry to write and with what data.

Every window move checks the mask bit of the window it is about to enter before the pointer changes. A move into a masked window raises an overflow or underflow trap and changes nothing. The return-from-trap request runs its checks in a fixed priority order. On success it restores the supervisor bit from the saved copy. The register storage, the address adder feeding the program counter, and trap vectoring all live outside this block.

A request is sampled on a rising edge. Its response and the new state are visible from that same edge until the next one.

Top module: `winptr_ctrl`

## Requirements
- R1: A push request (req_op=0) with mask bit clear for window (cwp-1) mod 8 sets cwp to that window and writes req_a+req_b into the destination register of the new window.
- R2: A pop request (req_op=1) with mask bit clear for window (cwp+1) mod 8 sets cwp to that window and writes req_a+req_b into the destination register of the new window.
- R3: If the mask bit of the target window is set, a push reports code 1 (overflow) and a pop reports code 2 (underflow). Neither changes cwp or writes a register.
- R4: For a destination index rd greater than 7, rsp_win is 1 and rsp_idx is ((window<<4)+rd) mod 128. For rd of 7 or less, rsp_win is 0 and rsp_idx equals rd.
- R5: A return from trap (req_op=2) checks in this order and reports the first failure. Trap enable already set gives code 4 (illegal). Supervisor clear gives code 3 (privileged). The mask bit of window (cwp+1) mod 8 set gives code 2. Bits [1:0] of req_a+req_b not both zero give code 5 (unaligned).
- R6: A successful return from trap sets cwp to (cwp+1) mod 8, sets trap enable, copies the previous-supervisor bit into supervisor, and writes no register.
- R7: A mask write (req_op=4) in supervisor mode loads wim with bits [7:0] of req_a XOR req_b and writes no register. Outside supervisor mode it reports code 3 and leaves wim unchanged.
- R8: A mask read (req_op=3) in supervisor mode writes wim, zero-extended, into destination rd of the current window. Outside supervisor mode it reports code 3 and writes nothing.
- R9: A trap entry (req_op=5) never traps. It clears trap enable, copies supervisor into previous supervisor, sets supervisor, and sets cwp to (cwp-1) mod 8 without a mask check.
- R10: Operation codes 6 and 7 report code 4 and change no state.
- R11: After reset, cwp=0, wim=0, supervisor=1, trap enable=0, previous supervisor=0, and all response outputs are 0.
- R12: Each accepted request gives rsp_valid=1 for one cycle with a single trap code (0 = none). A trapping request changes no state and writes no register. A cycle with no request gives rsp_valid=0 and all response fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 push, 1 pop, 2 return, 3 mask read, 4 mask write, 5 trap entry) |
| req_rd | input | 5 | Destination register number |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| rsp_valid | output | 1 | Response for the request sampled at the last edge |
| rsp_trap | output | 3 | Trap code, 0 when none |
| rsp_wen | output | 1 | Register write requested |
| rsp_win | output | 1 | 1 when rsp_idx is a windowed index, 0 for a global register |
| rsp_idx | output | 7 | Physical register index |
| rsp_data | output | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| wim_o | output | 8 | Window invalid mask |
| et_o | output | 1 | Trap enable |
| s_o | output | 1 | Supervisor |
| ps_o | output | 1 | Previous supervisor |

## Verification
Pushes and pops are run across the wrap between windows 0 and 7 and against masks with single bits set. This shows whether the check uses the target window rather than the current one, and whether the update is suppressed. Return-from-trap requests are made with several failing conditions true at once. These are trap enable together with user mode, and a masked target together with a misaligned address, so a wrong priority order yields a different code. Destination numbers on both sides of 7, and in the upper half of a window, show the global path, the windowed path and the overlap wrap modulo 128. A long stretch of mixed operations with random masks and operands is then compared against the reference model on every cycle.

// File: rtl/winptr_pkg.sv
// Package: shared operation and trap codes for the window pointer controller.
// Assumes: codes are 3 bits wide; unlisted operation codes are illegal.
package winptr_pkg;

    typedef enum logic [2:0] {
        OP_PUSH    = 3'd0,
        OP_POP     = 3'd1,
        OP_RETURN  = 3'd2,
        OP_MASK_RD = 3'd3,
        OP_MASK_WR = 3'd4,
        OP_TRAP_IN = 3'd5
    } win_op_e;

    typedef enum logic [2:0] {
        TR_NONE  = 3'd0,
        TR_WOVF  = 3'd1,
        TR_WUNF  = 3'd2,
        TR_PRIV  = 3'd3,
        TR_ILL   = 3'd4,
        TR_ALIGN = 3'd5
    } win_trap_e;

endpackage

// File: rtl/winptr_decide.sv
// Module: winptr_decide
// Purely combinational. Given the current state and one request, it picks the
// single trap (if any), the state the request would commit, the window whose
// frame receives the write, and the write data.
// Assumes: WIN_CNT is a power of two, so pointer arithmetic wraps naturally.
module winptr_decide
    import winptr_pkg::*;
#(
    parameter int WIN_CNT = 8,
    parameter int DATA_W  = 32,
    localparam int CWP_W  = $clog2(WIN_CNT)
) (
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic [CWP_W-1:0]   cwp,
    input  logic [WIN_CNT-1:0] wim,
    input  logic               et,
    input  logic               sup,
    input  logic               psup,
    output win_trap_e          trap,
    output logic [CWP_W-1:0]   nxt_cwp,
    output logic [WIN_CNT-1:0] nxt_wim,
    output logic               nxt_et,
    output logic               nxt_sup,
    output logic               nxt_psup,
    output logic               wen,
    output logic [CWP_W-1:0]   dst_win,
    output logic [DATA_W-1:0]  wdata
);

    logic [CWP_W-1:0]  cwp_dn;
    logic [CWP_W-1:0]  cwp_up;
    logic [DATA_W-1:0] sum;

    // Neighbouring windows and the shared operand sum.
    always_comb begin
        cwp_dn = cwp - CWP_W'(1);
        cwp_up = cwp + CWP_W'(1);
        sum    = opa + opb;
    end

    // Decide trap, committed state and write for the request.
    always_comb begin
        trap     = TR_NONE;
        nxt_cwp  = cwp;
        nxt_wim  = wim;
        nxt_et   = et;
        nxt_sup  = sup;
        nxt_psup = psup;
        wen      = 1'b0;
        dst_win  = cwp;
        wdata    = '0;
        case (win_op_e'(op))
            OP_PUSH: begin
                if (wim[cwp_dn]) begin
                    trap = TR_WOVF;
                end else begin
                    nxt_cwp = cwp_dn;
                    wen     = 1'b1;
                    dst_win = cwp_dn;
                    wdata   = sum;
                end
            end
            OP_POP: begin
                if (wim[cwp_up]) begin
                    trap = TR_WUNF;
                end else begin
                    nxt_cwp = cwp_up;
                    wen     = 1'b1;
                    dst_win = cwp_up;
                    wdata   = sum;
                end
            end
            OP_RETURN: begin
                if (et) begin
                    trap = TR_ILL;
                end else if (!sup) begin
                    trap = TR_PRIV;
                end else if (wim[cwp_up]) begin
                    trap = TR_WUNF;
                end else if (sum[1:0] != 2'b00) begin
                    trap = TR_ALIGN;
                end else begin
                    nxt_cwp = cwp_up;
                    nxt_et  = 1'b1;
                    nxt_sup = psup;
                end
            end
            OP_MASK_RD: begin
                if (!sup) begin
                    trap = TR_PRIV;
                end else begin
                    wen   = 1'b1;
                    wdata = DATA_W'(wim);
                end
            end
            OP_MASK_WR: begin
                if (!sup) begin
                    trap = TR_PRIV;
                end else begin
                    nxt_wim = opa[WIN_CNT-1:0] ^ opb[WIN_CNT-1:0];
                end
            end
            OP_TRAP_IN: begin
                nxt_cwp  = cwp_dn;
                nxt_et   = 1'b0;
                nxt_sup  = 1'b1;
                nxt_psup = sup;
            end
            default: trap = TR_ILL;
        endcase
    end

endmodule

// File: rtl/winptr_dest.sv
// Module: winptr_dest
// Maps a destination number onto the physical register file. Numbers below
// GLOB_CNT address the shared globals directly. Larger ones are offset by the
// window base, and the sum wraps over the whole windowed array.
// Assumes: each window advances the base by 2**WIN_SHIFT entries.
module winptr_dest #(
    parameter int WIN_CNT   = 8,
    parameter int RD_W      = 5,
    parameter int WIN_SHIFT = 4,
    parameter int GLOB_CNT  = 8,
    localparam int CWP_W    = $clog2(WIN_CNT),
    localparam int PHYS_W   = CWP_W + WIN_SHIFT
) (
    input  logic [CWP_W-1:0]  win,
    input  logic [RD_W-1:0]   rd,
    output logic              is_win,
    output logic [PHYS_W-1:0] idx
);

    logic [PHYS_W-1:0] base;

    // Window base address; the add below wraps modulo 2**PHYS_W.
    always_comb begin
        base = {win, {WIN_SHIFT{1'b0}}};
    end

    // Select the global or the windowed index.
    always_comb begin
        is_win = (32'(rd) >= GLOB_CNT);
        if (is_win) begin
            idx = base + PHYS_W'(rd);
        end else begin
            idx = PHYS_W'(rd);
        end
    end

endmodule

// File: rtl/winptr_state.sv
// Module: winptr_state
// Holds the pointer, the mask and the mode bits. It commits the decided next
// state only for an accepted request that raised no trap.
// Assumes: synchronous active-low reset; trap codes come from winptr_decide.
module winptr_state
    import winptr_pkg::*;
#(
    parameter int WIN_CNT = 8,
    localparam int CWP_W  = $clog2(WIN_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [2:0]         op,
    input  win_trap_e          trap,
    input  logic [CWP_W-1:0]   nxt_cwp,
    input  logic [WIN_CNT-1:0] nxt_wim,
    input  logic               nxt_et,
    input  logic               nxt_sup,
    input  logic               nxt_psup,
    output logic [CWP_W-1:0]   cwp,
    output logic [WIN_CNT-1:0] wim,
    output logic               et,
    output logic               sup,
    output logic               psup
);

    logic commit;

    // A request commits only when it raised no trap.
    always_comb begin
        commit = fire && (trap == TR_NONE);
    end

    // State registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp  <= '0;
            wim  <= '0;
            et   <= 1'b0;
            sup  <= 1'b1;
            psup <= 1'b0;
        end else if (commit) begin
            cwp  <= nxt_cwp;
            wim  <= nxt_wim;
            et   <= nxt_et;
            sup  <= nxt_sup;
            psup <= nxt_psup;
        end
    end

    // R3 / R12: a trapping request leaves every state bit untouched.
    a_r3_trap_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && trap != TR_NONE) |=> (cwp == $past(cwp) && wim == $past(wim)
            && et == $past(et) && sup == $past(sup) && psup == $past(psup)));

    // R1: a successful push moves the pointer down by one.
    a_r1_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == 3'd0 && trap == TR_NONE) |=> (cwp == $past(cwp) - CWP_W'(1)));

    // R6: a successful return enables traps and restores supervisor.
    a_r6_return_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == 3'd2 && trap == TR_NONE) |=> (et && sup == $past(psup)));

    // R9: trap entry disables traps and saves supervisor.
    a_r9_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == 3'd5) |=> (!et && sup && psup == $past(sup)));

endmodule

// File: rtl/winptr_ctrl.sv
// Module: winptr_ctrl (top)
// Window pointer controller: decides traps, commits window and mode state, and
// issues one registered response per accepted request.
// Assumes: one request per cycle; the response and the new state become
// visible together after the edge that sampled the request.
module winptr_ctrl
    import winptr_pkg::*;
#(
    parameter int WIN_CNT   = 8,
    parameter int DATA_W    = 32,
    parameter int RD_W      = 5,
    parameter int WIN_SHIFT = 4,
    parameter int GLOB_CNT  = 8,
    localparam int CWP_W    = $clog2(WIN_CNT),
    localparam int PHYS_W   = CWP_W + WIN_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [RD_W-1:0]    req_rd,
    input  logic [DATA_W-1:0]  req_a,
    input  logic [DATA_W-1:0]  req_b,
    output logic               rsp_valid,
    output logic [2:0]         rsp_trap,
    output logic               rsp_wen,
    output logic               rsp_win,
    output logic [PHYS_W-1:0]  rsp_idx,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [CWP_W-1:0]   cwp_o,
    output logic [WIN_CNT-1:0] wim_o,
    output logic               et_o,
    output logic               s_o,
    output logic               ps_o
);

    win_trap_e          trap;
    logic [CWP_W-1:0]   nxt_cwp;
    logic [WIN_CNT-1:0] nxt_wim;
    logic               nxt_et;
    logic               nxt_sup;
    logic               nxt_psup;
    logic               wen;
    logic [CWP_W-1:0]   dst_win;
    logic [DATA_W-1:0]  wdata;
    logic               is_win;
    logic [PHYS_W-1:0]  idx;

    winptr_decide #(.WIN_CNT(WIN_CNT), .DATA_W(DATA_W)) u_decide (
        .op(req_op), .opa(req_a), .opb(req_b),
        .cwp(cwp_o), .wim(wim_o), .et(et_o), .sup(s_o), .psup(ps_o),
        .trap(trap), .nxt_cwp(nxt_cwp), .nxt_wim(nxt_wim), .nxt_et(nxt_et),
        .nxt_sup(nxt_sup), .nxt_psup(nxt_psup),
        .wen(wen), .dst_win(dst_win), .wdata(wdata)
    );

    winptr_dest #(.WIN_CNT(WIN_CNT), .RD_W(RD_W), .WIN_SHIFT(WIN_SHIFT),
                  .GLOB_CNT(GLOB_CNT)) u_dest (
        .win(dst_win), .rd(req_rd), .is_win(is_win), .idx(idx)
    );

    winptr_state #(.WIN_CNT(WIN_CNT)) u_state (
        .clk(clk), .rst_n(rst_n), .fire(req_valid), .op(req_op), .trap(trap),
        .nxt_cwp(nxt_cwp), .nxt_wim(nxt_wim), .nxt_et(nxt_et),
        .nxt_sup(nxt_sup), .nxt_psup(nxt_psup),
        .cwp(cwp_o), .wim(wim_o), .et(et_o), .sup(s_o), .psup(ps_o)
    );

    // Response register: one cycle per request, all zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 3'd0;
            rsp_wen   <= 1'b0;
            rsp_win   <= 1'b0;
            rsp_idx   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_trap  <= trap;
            rsp_wen   <= wen;
            rsp_win   <= wen && is_win;
            rsp_idx   <= wen ? idx : '0;
            rsp_data  <= wdata;
        end
    end

    // R12: a trapped request never requests a register write.
    a_r12_no_write_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap != 3'd0) |-> !rsp_wen);

    // R12: an idle cycle reports nothing.
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_trap == 3'd0 && !rsp_wen));

endmodule

// File: tb/sim_winptr_ctrl.sv
// Bench: drives requests at the falling edge, advances a behavioural model at
// the rising edge, and compares every output shortly after that edge.
module sim_winptr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [4:0]  req_rd = 5'd0;
    logic [31:0] req_a = 32'd0;
    logic [31:0] req_b = 32'd0;
    logic        rsp_valid, rsp_wen, rsp_win, et_o, s_o, ps_o;
    logic [2:0]  rsp_trap, cwp_o;
    logic [6:0]  rsp_idx;
    logic [31:0] rsp_data;
    logic [7:0]  wim_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Reference model state.
    int m_cwp, m_wim, m_et, m_s, m_ps;
    int e_valid, e_trap, e_wen, e_win, e_idx;
    logic [31:0] e_data;

    always #10 clk = ~clk;

    winptr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_rd(req_rd), .req_a(req_a), .req_b(req_b),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_wen(rsp_wen),
        .rsp_win(rsp_win), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .cwp_o(cwp_o), .wim_o(wim_o), .et_o(et_o), .s_o(s_o), .ps_o(ps_o)
    );

    task automatic model_reset();
        m_cwp = 0; m_wim = 0; m_et = 0; m_s = 1; m_ps = 0;
        e_valid = 0; e_trap = 0; e_wen = 0; e_win = 0; e_idx = 0; e_data = 0;
    endtask

    task automatic model_write(input int w, input int rd, input logic [31:0] d);
        e_wen = 1;
        e_data = d;
        if (rd > 7) begin
            e_win = 1;
            e_idx = (w * 16 + rd) % 128;
        end else begin
            e_win = 0;
            e_idx = rd;
        end
    endtask

    task automatic model_step(input bit v, input int op, input int rd,
                              input logic [31:0] a, input logic [31:0] b);
        int n;
        logic [31:0] sum;
        e_valid = v; e_trap = 0; e_wen = 0; e_win = 0; e_idx = 0; e_data = 0;
        sum = a + b;
        if (!v) return;
        case (op)
            0: begin
                n = (m_cwp + 7) % 8;
                if ((m_wim >> n) & 1) e_trap = 1;
                else begin m_cwp = n; model_write(n, rd, sum); end
            end
            1: begin
                n = (m_cwp + 1) % 8;
                if ((m_wim >> n) & 1) e_trap = 2;
                else begin m_cwp = n; model_write(n, rd, sum); end
            end
            2: begin
                n = (m_cwp + 1) % 8;
                if (m_et == 1) e_trap = 4;
                else if (m_s == 0) e_trap = 3;
                else if ((m_wim >> n) & 1) e_trap = 2;
                else if (sum[1:0] != 0) e_trap = 5;
                else begin m_cwp = n; m_et = 1; m_s = m_ps; end
            end
            3: begin
                if (m_s == 0) e_trap = 3;
                else model_write(m_cwp, rd, 32'(m_wim));
            end
            4: begin
                if (m_s == 0) e_trap = 3;
                else m_wim = int'((a ^ b) & 32'hFF);
            end
            5: begin
                m_ps = m_s; m_s = 1; m_et = 0; m_cwp = (m_cwp + 7) % 8;
            end
            default: e_trap = 4;
        endcase
    endtask

    task automatic cmp(input string tag, input string nm, input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
            bad = 1;
        end
    endtask

    task automatic compare_all(input string tag);
        bit bad = 0;
        vectors++;
        cmp(tag, "rsp_valid", int'(rsp_valid), e_valid, bad);
        cmp(tag, "rsp_trap", int'(rsp_trap), e_trap, bad);
        cmp(tag, "rsp_wen", int'(rsp_wen), e_wen, bad);
        cmp(tag, "rsp_win", int'(rsp_win), e_win, bad);
        cmp(tag, "rsp_idx", int'(rsp_idx), e_idx, bad);
        cmp(tag, "rsp_data", int'(rsp_data), int'(e_data), bad);
        cmp(tag, "cwp", int'(cwp_o), m_cwp, bad);
        cmp(tag, "wim", int'(wim_o), m_wim, bad);
        cmp(tag, "et", int'(et_o), m_et, bad);
        cmp(tag, "s", int'(s_o), m_s, bad);
        cmp(tag, "ps", int'(ps_o), m_ps, bad);
        if (bad) misses++;
    endtask

    // Apply one request (or an idle cycle) and check the outcome.
    task automatic step(input bit v, input int op, input int rd,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        req_valid = v; req_op = 3'(op); req_rd = 5'(rd); req_a = a; req_b = b;
        @(posedge clk);
        model_step(v, op, rd, a, b);
        #5;
        compare_all(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        compare_all("R11");                              // R11 reset state
        step(0, 0, 0, 0, 0, "R12");                       // R12 idle quiet
        step(1, 0, 16, 32'd5, 32'd7, "R1");               // R1 push wraps 0->7, idx wraps to 0
        step(1, 0, 3, 32'd1, 32'd2, "R4");                // R4 global destination
        step(1, 1, 8, 32'hFFFF_FFFF, 32'd1, "R2");        // R2 pop, idx 120
        step(1, 1, 31, 32'd9, 32'd9, "R2");               // R2 pop wraps 7->0
        step(1, 4, 0, 32'h1234_5681, 32'h0, "R7");        // R7 mask = 0x81
        step(1, 0, 12, 32'd1, 32'd1, "R3");               // R3 overflow into window 7
        step(1, 1, 12, 32'd1, 32'd1, "R2");               // to window 1
        step(1, 0, 12, 32'd1, 32'd1, "R3");               // R3 overflow into window 0
        step(1, 4, 0, 32'h4, 32'h0, "R7");                // mask = 0x04
        step(1, 1, 20, 32'd3, 32'd4, "R3");               // R3 underflow into window 2
        step(1, 3, 20, 32'd0, 32'd0, "R8");               // R8 mask read, current window
        step(1, 2, 0, 32'h101, 32'h0, "R5");              // R5 masked and misaligned: underflow wins
        step(1, 4, 0, 32'h0, 32'h0, "R7");                // mask cleared
        step(1, 2, 0, 32'h100, 32'h2, "R5");              // R5 misaligned -> code 5
        step(1, 2, 0, 32'h100, 32'h4, "R6");              // R6 success, s <- ps = 0
        step(1, 2, 0, 32'h100, 32'h4, "R5");              // R5 et and user both true -> illegal
        step(1, 4, 0, 32'hFF, 32'h0, "R7");               // R7 user write -> privileged
        step(1, 3, 9, 32'h0, 32'h0, "R8");                // R8 user read -> privileged
        step(1, 5, 0, 32'h0, 32'h0, "R9");                // R9 trap entry from user
        step(1, 5, 0, 32'h0, 32'h0, "R9");                // R9 nested entry, ps = 1
        step(1, 6, 10, 32'h0, 32'h0, "R10");              // R10 illegal code
        step(1, 7, 10, 32'h0, 32'h0, "R10");              // R10 illegal code
        step(1, 2, 0, 32'h200, 32'h0, "R6");              // R6 return, s <- 1
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op > 7) op = op - 8;
            step(($urandom_range(0, 7) != 0), op, $urandom_range(0, 31),
                 $urandom(), ($urandom_range(0, 1) != 0) ? $urandom() : 32'h4, "R12");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule